// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation converter. It has one conversion-clock enable, `tad_tick`, and every timed step advances on that enable. A start request comes from software or from an external trigger pulse. The block then holds the sample switch closed for a programmable number of ticks. Next it opens the switch and resolves the code one bit per tick, most significant bit first, by driving trial codes to the DAC and reading a comparator.

A finished conversion loads the result register, clears the busy (start/status) bit, raises a sticky interrupt flag and closes the sample switch, all on the same edge. Software can clear the busy bit mid-run to abort; the stored result is then left alone. Every completion or abort is followed by a fixed two-tick hold-off before a new acquisition may begin. A start that arrives during the hold-off is kept and runs once the hold-off ends. Each trigger pulse also makes a one-clock clear pulse for a companion timer, whether or not the converter is enabled.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, busy, interrupt flag, result, DAC code and timer clear are all 0, and the sample switch is closed.
- R2: A software start sets busy on the next clock when enabled. When enable is 0 it is ignored: busy stays 0 and the switch stays closed.
- R3: Acquisition lasts the number of ticks picked by acq_sel: 000→0, 001→2, 010→4, 011→6, 100→8, 101→12, 110→16, 111→20. With 000 the switch opens on the clock after the start.
- R4: With the switch open, each tick decides one bit, from bit 9 down to bit 0. A bit stays 1 when cmp_ge is 1 (input ≥ DAC code) and is cleared otherwise. The switch stays open for exactly 11 ticks, and the result equals the input code.
- R5: On completion the result is loaded, busy falls, irq_flag rises and the switch closes, all on the same edge.
- R6: Clearing busy during acquisition or conversion aborts the run. The switch closes, busy falls, and neither the result nor irq_flag changes.
- R7: After any completion or abort the switch stays closed for 2 ticks. A start requested in that window is held and begins afterwards.
- R8: An external trigger starts a run like a software start, but only when enabled.
- R9: Every trigger pulse gives a one-clock timer_clr pulse on the next clock, enabled or not.
- R10: irq_flag stays set until irq_clr. A completion on the same edge as irq_clr leaves it set.
- R11: A software result write loads the result register. A completion on the same edge wins.
- R12: When a conversion begins, the DAC code is 10'h200 (only the MSB set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tad_tick | input | 1 | Conversion-clock enable, one clock wide |
| enable | input | 1 | Converter enable |
| sw_start_set | input | 1 | Software write of 1 to the start/status bit |
| sw_start_clr | input | 1 | Software write of 0 to the start/status bit (abort) |
| acq_sel | input | 3 | Acquisition-time select |
| ext_trig | input | 1 | External trigger pulse |
| res_wr_en | input | 1 | Software write strobe for the result register |
| res_wr_data | input | 10 | Software write data for the result register |
| irq_clr | input | 1 | Clears the interrupt flag |
| cmp_ge | input | 1 | Comparator: analog input ≥ DAC output |
| sample_closed | output | 1 | Sample switch closed (input connected) |
| dac_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Result register |
| busy | output | 1 | Start/status bit |
| irq_flag | output | 1 | Sticky interrupt flag |
| timer_clr | output | 1 | Companion timer clear pulse |

## Verification
Completion can land on the same clock as a software write to the status area. Two such writes are tested: clearing the interrupt flag and writing the result register. The bench counts conversion ticks and drives both writes in the cycle ahead of the eleventh tick. It then expects the flag still set and the converted code in the result. The same kind of collision is also provoked between an abort's hold-off and a start issued on the very next clock. That start must not open the switch until two ticks have passed.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } sar_state_e;

  localparam int SEL_W   = 3;
  localparam int ACQ_MAX = 20;
  localparam int ACQ_W   = $clog2(ACQ_MAX + 1);

  // acquisition length in conversion ticks for each select code
  function automatic logic [ACQ_W-1:0] acq_ticks(input logic [SEL_W-1:0] sel);
    logic [ACQ_W-1:0] n;
    case (sel)
      3'd0:    n = ACQ_W'(0);
      3'd1:    n = ACQ_W'(2);
      3'd2:    n = ACQ_W'(4);
      3'd3:    n = ACQ_W'(6);
      3'd4:    n = ACQ_W'(8);
      3'd5:    n = ACQ_W'(12);
      3'd6:    n = ACQ_W'(16);
      default: n = ACQ_W'(20);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sar_start_ctrl.sv
`timescale 1ns/1ps
module sar_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sw_start_set,
  input  logic sw_start_clr,
  input  logic ext_trig,
  input  logic ev_done,
  output logic go,
  output logic set_ev,
  output logic clr_ev,
  output logic timer_clr
);
  // a start request needs enable; it outranks clears and completion
  assign set_ev = enable && (sw_start_set || ext_trig);
  assign clr_ev = sw_start_clr && !set_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go        <= 1'b0;
      timer_clr <= 1'b0;
    end else begin
      timer_clr <= ext_trig;
      if (set_ev)
        go <= 1'b1;
      else if (clr_ev || ev_done)
        go <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_fsm.sv
`timescale 1ns/1ps
module sar_fsm
  import sar_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int HOLD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tad_tick,
  input  logic [SEL_W-1:0] acq_sel,
  input  logic             go,
  input  logic             set_ev,
  input  logic             clr_ev,
  output logic             sample_closed,
  output logic             ev_conv_begin,
  output logic             ev_step,
  output logic [$clog2(RES_W)-1:0] step_idx,
  output logic             ev_done,
  output logic             ev_abort
);
  localparam int IDX_W  = $clog2(RES_W);
  localparam int CONV_W = $clog2(RES_W + 1);
  localparam int HLD_W  = $clog2(HOLD_TICKS + 1);
  localparam int CW0    = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;
  localparam int CNT_W  = (CW0 > HLD_W) ? CW0 : HLD_W;

  sar_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [ACQ_W-1:0] acq_len;
  logic             want;
  logic             start_now;
  logic             acq_end;

  assign acq_len   = acq_ticks(acq_sel);
  assign want      = go || set_ev;
  assign ev_abort  = clr_ev && (st == ST_ACQ || st == ST_CONV);
  assign start_now = want && ((st == ST_IDLE) ||
                     (st == ST_HOLD && tad_tick && cnt == '0));
  assign acq_end   = (st == ST_ACQ) && tad_tick && cnt == '0 && !ev_abort;
  assign ev_conv_begin = (start_now && acq_len == '0) || acq_end;
  assign ev_step   = (st == ST_CONV) && tad_tick && !ev_abort &&
                     cnt < CNT_W'(RES_W);
  assign ev_done   = (st == ST_CONV) && tad_tick && !ev_abort &&
                     cnt == CNT_W'(RES_W);
  assign step_idx  = IDX_W'(RES_W - 1) - IDX_W'(cnt);
  assign sample_closed = (st != ST_CONV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (ev_abort || ev_done) begin
      st  <= ST_HOLD;
      cnt <= CNT_W'(HOLD_TICKS - 1);
    end else if (ev_conv_begin) begin
      st  <= ST_CONV;
      cnt <= '0;
    end else if (start_now) begin
      st  <= ST_ACQ;
      cnt <= CNT_W'(acq_len - ACQ_W'(1));
    end else if (tad_tick) begin
      case (st)
        ST_ACQ:  cnt <= cnt - CNT_W'(1);
        ST_CONV: cnt <= cnt + CNT_W'(1);
        ST_HOLD: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sar_datapath.sv
`timescale 1ns/1ps
module sar_datapath #(
  parameter int RES_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_conv_begin,
  input  logic                     ev_step,
  input  logic [$clog2(RES_W)-1:0] step_idx,
  input  logic                     ev_done,
  input  logic                     cmp_ge,
  input  logic                     res_wr_en,
  input  logic [RES_W-1:0]         res_wr_data,
  input  logic                     irq_clr,
  output logic [RES_W-1:0]         dac_code,
  output logic [RES_W-1:0]         result,
  output logic                     irq_flag
);
  localparam int IDX_W = $clog2(RES_W);

  // one approximation step: settle bit idx, then try the next lower bit
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] t,
                                                input logic [IDX_W-1:0] idx,
                                                input logic keep);
    logic [RES_W-1:0] r;
    r = t;
    r[idx] = keep;
    if (idx != '0) r[idx - IDX_W'(1)] = 1'b1;
    return r;
  endfunction

  logic [RES_W-1:0] trial;
  assign dac_code = trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial    <= '0;
      result   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (ev_conv_begin)
        trial <= {1'b1, {(RES_W-1){1'b0}}};
      else if (ev_step)
        trial <= sar_step(trial, step_idx, cmp_ge);

      if (ev_done)
        result <= trial;
      else if (res_wr_en)
        result <= res_wr_data;

      if (ev_done)
        irq_flag <= 1'b1;
      else if (irq_clr)
        irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int HOLD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tad_tick,
  input  logic             enable,
  input  logic             sw_start_set,
  input  logic             sw_start_clr,
  input  logic [SEL_W-1:0] acq_sel,
  input  logic             ext_trig,
  input  logic             res_wr_en,
  input  logic [RES_W-1:0] res_wr_data,
  input  logic             irq_clr,
  input  logic             cmp_ge,
  output logic             sample_closed,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             irq_flag,
  output logic             timer_clr
);
  localparam int IDX_W = $clog2(RES_W);

  logic             go;
  logic             set_ev;
  logic             clr_ev;
  logic             ev_conv_begin;
  logic             ev_step;
  logic             ev_done;
  logic             ev_abort;
  logic [IDX_W-1:0] step_idx;

  assign busy = go;

  sar_start_ctrl u_start (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .ext_trig(ext_trig), .ev_done(ev_done),
    .go(go), .set_ev(set_ev), .clr_ev(clr_ev), .timer_clr(timer_clr)
  );

  sar_fsm #(.RES_W(RES_W), .HOLD_TICKS(HOLD_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .acq_sel(acq_sel),
    .go(go), .set_ev(set_ev), .clr_ev(clr_ev),
    .sample_closed(sample_closed), .ev_conv_begin(ev_conv_begin),
    .ev_step(ev_step), .step_idx(step_idx),
    .ev_done(ev_done), .ev_abort(ev_abort)
  );

  sar_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ev_conv_begin(ev_conv_begin),
    .ev_step(ev_step), .step_idx(step_idx), .ev_done(ev_done),
    .cmp_ge(cmp_ge), .res_wr_en(res_wr_en), .res_wr_data(res_wr_data),
    .irq_clr(irq_clr), .dac_code(dac_code), .result(result),
    .irq_flag(irq_flag)
  );
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             ext_trig,
  input logic             res_wr_en,
  input logic             irq_clr,
  input logic             sample_closed,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             busy,
  input logic             irq_flag,
  input logic             timer_clr,
  input logic             ev_conv_begin,
  input logic             ev_done,
  input logic             ev_abort
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy); // R2
  AST_OPEN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_closed |-> busy); // R4
  AST_DONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (irq_flag && sample_closed)); // R5
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && !res_wr_en) |=> ($stable(result) && sample_closed)); // R6
  AST_TRIG_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig |=> timer_clr); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R10
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_conv_begin |=> (dac_code == {1'b1, {(RES_W-1){1'b0}}})); // R12
endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES_W(RES_W)) u_sar_seq_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ext_trig(ext_trig),
  .res_wr_en(res_wr_en), .irq_clr(irq_clr), .sample_closed(sample_closed),
  .dac_code(dac_code), .result(result), .busy(busy), .irq_flag(irq_flag),
  .timer_clr(timer_clr), .ev_conv_begin(ev_conv_begin),
  .ev_done(ev_done), .ev_abort(ev_abort)
);

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tad_tick = 1'b0;
  logic       enable = 1'b1;
  logic       sw_start_set = 1'b0;
  logic       sw_start_clr = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic       ext_trig = 1'b0;
  logic       res_wr_en = 1'b0;
  logic [9:0] res_wr_data = '0;
  logic       irq_clr = 1'b0;
  logic       cmp_ge;
  logic       sample_closed;
  logic [9:0] dac_code;
  logic [9:0] result;
  logic       busy;
  logic       irq_flag;
  logic       timer_clr;
  logic [9:0] ain = '0;
  int         total = 0;
  int         bad = 0;
  int         div = 0;

  // comparator model: analog input as a 10-bit code
  assign cmp_ge = (ain >= dac_code);

  sar_seq_ctrl i_sar_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .enable(enable),
    .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .acq_sel(acq_sel), .ext_trig(ext_trig), .res_wr_en(res_wr_en),
    .res_wr_data(res_wr_data), .irq_clr(irq_clr), .cmp_ge(cmp_ge),
    .sample_closed(sample_closed), .dac_code(dac_code), .result(result),
    .busy(busy), .irq_flag(irq_flag), .timer_clr(timer_clr)
  );

  always #2.5 clk = ~clk;

  // tick every fourth clock, changed just after the rising edge
  initial forever begin
    @(posedge clk);
    #1;
    tad_tick = (div == 3);
    div = (div + 1) % 4;
  end

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung (actual=timeout expected=finish)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 result", result, 0);
    chk("R1 dac", dac_code, 0);
    chk("R1 timer_clr", timer_clr, 0);
    chk("R1 sample", sample_closed, 1);
  endtask

  // software start, count acquisition and conversion ticks
  task automatic t_convert(input logic [2:0] sel, input logic [9:0] code,
                           input int exp_acq, input bit collide);
    int n = 0;
    int c = 0;
    int g = 0;
    ain = code;
    acq_sel = sel;
    sw_start_set = 1'b1;
    @(negedge clk);
    sw_start_set = 1'b0;
    chk("R2 busy after start", busy, 1);
    while (sample_closed && g < 400) begin
      if (tad_tick) n++;
      @(negedge clk);
      g++;
    end
    chk("R3 acquisition ticks", n, exp_acq);
    chk("R12 first trial code", dac_code, 10'h200);
    while (!sample_closed && g < 800) begin
      if (tad_tick) begin
        c++;
        if (c == 11 && collide) begin
          irq_clr = 1'b1;
          res_wr_en = 1'b1;
          res_wr_data = ~code;
        end
      end
      @(negedge clk);
      irq_clr = 1'b0;
      res_wr_en = 1'b0;
      g++;
    end
    chk("R4 conversion ticks", c, 11);
    chk("R4 result code", result, code);
    chk("R5 busy cleared", busy, 0);
    chk("R5 irq set", irq_flag, 1);
    if (collide) begin
      chk("R10 irq kept over clear", irq_flag, 1);
      chk("R11 completion over write", result, code);
    end
    repeat (6) @(negedge clk);
    chk("R10 irq sticky", irq_flag, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R10 irq cleared", irq_flag, 0);
    settle();
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    chk("R8 trigger ignored", busy, 0);
    chk("R9 timer clear while disabled", timer_clr, 1);
    @(negedge clk);
    chk("R9 timer clear one clock", timer_clr, 0);
    sw_start_set = 1'b1;
    @(negedge clk);
    sw_start_set = 1'b0;
    chk("R2 start ignored", busy, 0);
    repeat (8) @(negedge clk);
    chk("R2 switch stays closed", sample_closed, 1);
    enable = 1'b1;
  endtask

  task automatic t_trigger(input logic [9:0] code);
    int g = 0;
    ain = code;
    acq_sel = 3'd1;
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    chk("R8 trigger starts", busy, 1);
    chk("R9 timer clear enabled", timer_clr, 1);
    while (busy && g < 800) begin
      @(negedge clk);
      g++;
    end
    chk("R8 trigger result", result, code);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    settle();
  endtask

  // abort after some ticks, then a start straight into the hold-off
  task automatic t_abort(input logic [2:0] sel, input bit in_conv, input int wait_ticks);
    int n = 0;
    int g = 0;
    logic [9:0] keep;
    keep = result;
    ain = 10'h3C5;
    acq_sel = sel;
    sw_start_set = 1'b1;
    @(negedge clk);
    sw_start_set = 1'b0;
    if (in_conv)
      while (sample_closed && g < 400) begin @(negedge clk); g++; end
    while (n < wait_ticks && g < 800) begin
      if (tad_tick) n++;
      @(negedge clk);
      g++;
    end
    sw_start_clr = 1'b1;
    @(negedge clk);
    sw_start_clr = 1'b0;
    chk("R6 busy dropped", busy, 0);
    chk("R6 switch closed", sample_closed, 1);
    chk("R6 result kept", result, keep);
    chk("R6 no irq", irq_flag, 0);
    acq_sel = 3'd0;
    sw_start_set = 1'b1;
    n = 0;
    while (sample_closed && g < 1200) begin
      if (tad_tick) n++;
      @(negedge clk);
      sw_start_set = 1'b0;
      g++;
    end
    chk("R7 hold-off ticks", n, 2);
    while (busy && g < 2000) begin @(negedge clk); g++; end
    chk("R7 held start converts", result, 10'h3C5);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert(3'd0, 10'h2AA, 0, 1'b0);
    t_convert(3'd2, 10'h155, 4, 1'b0);
    t_convert(3'd7, 10'h3FF, 20, 1'b0);
    t_convert(3'd1, 10'h000, 2, 1'b0);
    t_convert(3'd3, 10'h200, 6, 1'b0);
    t_convert(3'd4, 10'h1FF, 8, 1'b0);
    t_convert(3'd5, 10'h001, 12, 1'b0);
    t_convert(3'd6, 10'h0F3, 16, 1'b1);
    t_disabled();
    t_trigger(10'h2D7);
    res_wr_en = 1'b1;
    res_wr_data = 10'h123;
    @(negedge clk);
    res_wr_en = 1'b0;
    chk("R11 software write", result, 10'h123);
    t_abort(3'd2, 1'b1, 3);
    res_wr_en = 1'b1;
    res_wr_data = 10'h0AB;
    @(negedge clk);
    res_wr_en = 1'b0;
    t_abort(3'd7, 1'b0, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule